// File: doc/BRIEF.md
# Key-Gated One-Time-Programmable Packet Command Front End

This block is the write-only command register that sits in front of a one-time-programmable packet controller. A bus master writes a 32-bit word. The block decodes that word into single-cycle command strobes for the engines behind it: program, checksum generate, invalidate, hide, read, flush, refresh, and start or stop of a transfer on the host key bus. The OTP array, the checksum arithmetic, the key-bus engine and the payload storage are not part of this block. It only issues the strobes, together with the index of the packet each strobe applies to.

Four commands are privileged: program, checksum generate, invalidate and hide. They act only when the upper half of the written word carries the unlock key. A write-protection input blocks every write. For each packet the block keeps three flags. The hidden flag is cleared by reset. The locked and invalid flags are loaded at reset from initial-state inputs, which model the values held in the OTP. A packet that is hidden refuses reads, and a packet that is locked refuses programming. While the downstream engine reports busy, privileged commands and reads are refused. Two sticky error flags record a wrong key and a command attempted while busy.

Top module: `otp_cmd_front`

## Requirements
- R1: While `wprot_en` is high, a write has no effect: no strobe is issued, no packet flag changes and neither error flag is set.
- R2: Program, checksum generate, invalidate and hide take effect only when bits 31:16 of the written word equal 0x7167. If any of them is requested with another key value, the command gets no strobe, changes no packet flag, and sets the sticky `key_err` flag.
- R3: The command bits are: program at bit 0, checksum generate at bit 1, invalidate at bit 2, hide at bit 4, read at bit 6, flush at bit 7, key-bus start at bit 8, key-bus stop at bit 9 and refresh at bit 15. A granted command raises its strobe for exactly one cycle, in the cycle after the write. Zero bits have no effect.
- R4: A granted hide sets the hidden flag of the selected packet. Reads of a hidden packet are refused until the next reset.
- R5: A granted checksum generate sets the locked flag of the selected packet. Program commands to a locked packet are refused.
- R6: A granted invalidate sets the invalid flag of the selected packet.
- R7: Read, flush, refresh, key-bus start and key-bus stop are accepted whatever the key field holds.
- R8: When one write requests several commands, only the permitted command with the lowest bit number is issued.
- R9: While `busy_in` is high, privileged commands and reads are refused, and a request for any of them sets the sticky `busy_err` flag. Key-bus stop, key-bus start, flush and refresh are still accepted.
- R10: Reset clears all strobes, both error flags and every hidden flag. It loads the locked flags from `init_locked` and the invalid flags from `init_invalid`.
- R11: `stb_pkt` carries the packet index that the issued strobe applies to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 32 | Command word: key in 31:16, command bits below |
| wprot_en | input | 1 | Write protection; blocks all writes when high |
| busy_in | input | 1 | Downstream engine busy |
| pkt_sel | input | 4 | Selected packet index |
| init_locked | input | 16 | Locked flags loaded at reset |
| init_invalid | input | 16 | Invalid flags loaded at reset |
| prog_stb | output | 1 | Program strobe |
| cksum_stb | output | 1 | Checksum generate strobe |
| inval_stb | output | 1 | Invalidate strobe |
| hide_stb | output | 1 | Hide strobe |
| read_stb | output | 1 | Read strobe |
| flush_stb | output | 1 | Flush strobe |
| kb_start_stb | output | 1 | Key-bus transfer start strobe |
| kb_stop_stb | output | 1 | Key-bus transfer stop strobe |
| refresh_stb | output | 1 | Refresh strobe |
| stb_pkt | output | 4 | Packet index for the issued strobe |
| key_err | output | 1 | Sticky wrong-key flag |
| busy_err | output | 1 | Sticky command-while-busy flag |
| hidden_flags | output | 16 | Per-packet hidden flags |
| locked_flags | output | 16 | Per-packet locked flags |
| invalid_flags | output | 16 | Per-packet invalid flags |

## Verification
The assertions check these rules on every cycle:
- at most one strobe is high at any time;
- a protected write or a wrong-key write never produces a privileged strobe;
- a write while busy produces no privileged or read strobe;
- reads of a hidden packet and programs of a locked packet are refused;
- hidden and locked flags never fall except through reset.

Other behaviour can only be shown by the bench's scenarios:
- which command wins when several are requested together, as the packet flags change;
- that the error flags accumulate correctly;
- that the initial-state inputs are sampled again on a second reset;
- that a hidden packet becomes readable again after that reset.

// File: rtl/otp_cmd_pkg.sv
package otp_cmd_pkg;

  // Command slots, ordered by ascending bit number in the command word.
  localparam int NCMD     = 9;
  localparam int C_PROG   = 0;
  localparam int C_CKSUM  = 1;
  localparam int C_INVAL  = 2;
  localparam int C_HIDE   = 3;
  localparam int C_READ   = 4;
  localparam int C_FLUSH  = 5;
  localparam int C_KBGO   = 6;
  localparam int C_KBHALT = 7;
  localparam int C_REFR   = 8;

  localparam int          KEY_W      = 16;
  localparam logic [15:0] UNLOCK_KEY = 16'h7167;

  // Slots that need the key, and slots that busy refuses.
  localparam logic [NCMD-1:0] PRIV_MASK = 9'b0_0000_1111;
  localparam logic [NCMD-1:0] BUSY_MASK = 9'b0_0001_1111;

  // Bit position in the written word of each command slot.
  function automatic int cmd_bit(input int slot);
    case (slot)
      C_PROG:   return 0;
      C_CKSUM:  return 1;
      C_INVAL:  return 2;
      C_HIDE:   return 4;
      C_READ:   return 6;
      C_FLUSH:  return 7;
      C_KBGO:   return 8;
      C_KBHALT: return 9;
      default:  return 15;
    endcase
  endfunction

endpackage

// File: rtl/otp_cmd_decode.sv
module otp_cmd_decode
  import otp_cmd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wprot_en,
  input  logic              busy_in,
  input  logic              sel_hidden,
  input  logic              sel_locked,
  output logic [NCMD-1:0]   grant,
  output logic              key_bad,
  output logic              busy_bad
);

  localparam int KEY_LSB = DATA_W - KEY_W;

  logic              accept;
  logic              key_ok;
  logic [NCMD-1:0]   req;
  logic [NCMD-1:0]   permit;
  logic [NCMD:0]     taken;
  logic              unused_cmd_bits;

  assign accept = wr_en & ~wprot_en;
  assign key_ok = (wr_data[KEY_LSB +: KEY_W] == UNLOCK_KEY);

  // Bits of the command field that carry no command.
  assign unused_cmd_bits = ^{wr_data[3], wr_data[5], wr_data[14:10]};

  genvar gi;
  generate
    for (gi = 0; gi < NCMD; gi++) begin : g_req
      localparam int BITPOS = cmd_bit(gi);
      assign req[gi] = accept & wr_data[BITPOS];
    end
  endgenerate

  always_comb begin
    permit = req;
    for (int i = 0; i < NCMD; i++) begin
      if (PRIV_MASK[i] && !key_ok) permit[i] = 1'b0;
      if (BUSY_MASK[i] && busy_in) permit[i] = 1'b0;
    end
    if (sel_locked) permit[C_PROG] = 1'b0;
    if (sel_hidden) permit[C_READ] = 1'b0;
  end

  // Lowest permitted slot wins.
  assign taken[0] = 1'b0;
  generate
    for (gi = 0; gi < NCMD; gi++) begin : g_pick
      assign grant[gi]   = permit[gi] & ~taken[gi];
      assign taken[gi+1] = taken[gi] | permit[gi];
    end
  endgenerate

  assign key_bad  = (|(req & PRIV_MASK)) & ~key_ok;
  assign busy_bad = (|(req & BUSY_MASK)) & busy_in;

  // R8: the picker never grants two commands.
  always_comb begin
    a_r8_single_grant: assert ($onehot0(grant));
  end

endmodule

// File: rtl/otp_pkt_table.sv
module otp_pkt_table #(
  parameter int NPKT  = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPKT-1:0]  init_locked,
  input  logic [NPKT-1:0]  init_invalid,
  input  logic [IDX_W-1:0] sel,
  input  logic             set_hidden,
  input  logic             set_locked,
  input  logic             set_invalid,
  output logic [NPKT-1:0]  hidden_q,
  output logic [NPKT-1:0]  locked_q,
  output logic [NPKT-1:0]  invalid_q,
  output logic             sel_hidden,
  output logic             sel_locked
);

  logic sel_valid;
  assign sel_valid = (int'(sel) < NPKT);

  genvar gp;
  generate
    for (gp = 0; gp < NPKT; gp++) begin : g_pkt
      logic hit;
      assign hit = sel_valid && (int'(sel) == gp);
      always_ff @(posedge clk) begin
        if (rst) begin
          hidden_q[gp]  <= 1'b0;
          locked_q[gp]  <= init_locked[gp];
          invalid_q[gp] <= init_invalid[gp];
        end else if (hit) begin
          if (set_hidden)  hidden_q[gp]  <= 1'b1;
          if (set_locked)  locked_q[gp]  <= 1'b1;
          if (set_invalid) invalid_q[gp] <= 1'b1;
        end
      end
    end
  endgenerate

  assign sel_hidden = sel_valid ? hidden_q[sel] : 1'b1;
  assign sel_locked = sel_valid ? locked_q[sel] : 1'b1;

  // R4: a hidden flag stays set until reset.
  a_r4_hidden_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((hidden_q & $past(hidden_q)) == $past(hidden_q)));

  // R5: a locked flag stays set until reset.
  a_r5_locked_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((locked_q & $past(locked_q)) == $past(locked_q)));

  // R6: an invalid flag stays set until reset.
  a_r6_invalid_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((invalid_q & $past(invalid_q)) == $past(invalid_q)));

endmodule

// File: rtl/otp_cmd_front.sv
module otp_cmd_front
  import otp_cmd_pkg::*;
#(
  parameter int NPKT   = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = (NPKT > 1) ? $clog2(NPKT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wprot_en,
  input  logic              busy_in,
  input  logic [IDX_W-1:0]  pkt_sel,
  input  logic [NPKT-1:0]   init_locked,
  input  logic [NPKT-1:0]   init_invalid,
  output logic              prog_stb,
  output logic              cksum_stb,
  output logic              inval_stb,
  output logic              hide_stb,
  output logic              read_stb,
  output logic              flush_stb,
  output logic              kb_start_stb,
  output logic              kb_stop_stb,
  output logic              refresh_stb,
  output logic [IDX_W-1:0]  stb_pkt,
  output logic              key_err,
  output logic              busy_err,
  output logic [NPKT-1:0]   hidden_flags,
  output logic [NPKT-1:0]   locked_flags,
  output logic [NPKT-1:0]   invalid_flags
);

  localparam int KEY_LSB = DATA_W - KEY_W;

  logic [NCMD-1:0]  grant;
  logic [NCMD-1:0]  stb_q;
  logic [IDX_W-1:0] pkt_q;
  logic             key_bad, busy_bad;
  logic             sel_hidden, sel_locked;
  logic             key_err_q, busy_err_q;

  otp_pkt_table #(
    .NPKT  (NPKT),
    .IDX_W (IDX_W)
  ) u_table (
    .clk          (clk),
    .rst          (rst),
    .init_locked  (init_locked),
    .init_invalid (init_invalid),
    .sel          (pkt_sel),
    .set_hidden   (grant[C_HIDE]),
    .set_locked   (grant[C_CKSUM]),
    .set_invalid  (grant[C_INVAL]),
    .hidden_q     (hidden_flags),
    .locked_q     (locked_flags),
    .invalid_q    (invalid_flags),
    .sel_hidden   (sel_hidden),
    .sel_locked   (sel_locked)
  );

  otp_cmd_decode #(
    .DATA_W (DATA_W)
  ) u_decode (
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .wprot_en   (wprot_en),
    .busy_in    (busy_in),
    .sel_hidden (sel_hidden),
    .sel_locked (sel_locked),
    .grant      (grant),
    .key_bad    (key_bad),
    .busy_bad   (busy_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q      <= '0;
      pkt_q      <= '0;
      key_err_q  <= 1'b0;
      busy_err_q <= 1'b0;
    end else begin
      stb_q <= grant;
      if (|grant)   pkt_q      <= pkt_sel;
      if (key_bad)  key_err_q  <= 1'b1;
      if (busy_bad) busy_err_q <= 1'b1;
    end
  end

  assign prog_stb     = stb_q[C_PROG];
  assign cksum_stb    = stb_q[C_CKSUM];
  assign inval_stb    = stb_q[C_INVAL];
  assign hide_stb     = stb_q[C_HIDE];
  assign read_stb     = stb_q[C_READ];
  assign flush_stb    = stb_q[C_FLUSH];
  assign kb_start_stb = stb_q[C_KBGO];
  assign kb_stop_stb  = stb_q[C_KBHALT];
  assign refresh_stb  = stb_q[C_REFR];
  assign stb_pkt      = pkt_q;
  assign key_err      = key_err_q;
  assign busy_err     = busy_err_q;

  // R8: at most one strobe is visible at a time.
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_stb, cksum_stb, inval_stb, hide_stb, read_stb,
              flush_stb, kb_start_stb, kb_stop_stb, refresh_stb}));

  // R1: a protected write issues nothing and leaves both error flags alone.
  a_r1_protected: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wprot_en) |=>
      (stb_q == '0 && $stable(key_err) && $stable(busy_err)));

  // R2: a wrong key never yields a privileged strobe.
  a_r2_key_gate: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[KEY_LSB +: KEY_W] != UNLOCK_KEY) |=>
      !(prog_stb || cksum_stb || inval_stb || hide_stb));

  // R9: busy blocks privileged commands and reads.
  a_r9_busy_block: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy_in) |=>
      !(prog_stb || cksum_stb || inval_stb || hide_stb || read_stb));

  // R4: no read strobe for a packet that is hidden.
  a_r4_hidden_read: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(pkt_sel) < NPKT && hidden_flags[pkt_sel]) |=> !read_stb);

  // R5: no program strobe for a packet that is locked.
  a_r5_locked_prog: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(pkt_sel) < NPKT && locked_flags[pkt_sel]) |=> !prog_stb);

  // R2: the key error flag stays set until reset.
  a_r2_key_err_sticky: assert property (@(posedge clk) disable iff (rst)
    key_err |=> key_err);

endmodule

// File: tb/tb_otp_cmd_front.sv
`timescale 1ns/1ps
module tb_otp_cmd_front;

  localparam int NPKT = 16;
  localparam logic [15:0] KEY = 16'h7167;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, wprot_en, busy_in;
  logic [31:0] wr_data;
  logic [3:0]  pkt_sel;
  logic [15:0] init_locked, init_invalid;
  logic prog_stb, cksum_stb, inval_stb, hide_stb, read_stb, flush_stb;
  logic kb_start_stb, kb_stop_stb, refresh_stb, key_err, busy_err;
  logic [3:0]  stb_pkt;
  logic [15:0] hidden_flags, locked_flags, invalid_flags;

  always #2.5 clk = ~clk;

  otp_cmd_front dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .wprot_en(wprot_en), .busy_in(busy_in), .pkt_sel(pkt_sel),
    .init_locked(init_locked), .init_invalid(init_invalid),
    .prog_stb(prog_stb), .cksum_stb(cksum_stb), .inval_stb(inval_stb),
    .hide_stb(hide_stb), .read_stb(read_stb), .flush_stb(flush_stb),
    .kb_start_stb(kb_start_stb), .kb_stop_stb(kb_stop_stb),
    .refresh_stb(refresh_stb), .stb_pkt(stb_pkt), .key_err(key_err),
    .busy_err(busy_err), .hidden_flags(hidden_flags),
    .locked_flags(locked_flags), .invalid_flags(invalid_flags)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Strobe vector: bit0 prog, 1 cksum, 2 inval, 3 hide, 4 read,
  // 5 flush, 6 kb start, 7 kb stop, 8 refresh.
  function automatic logic [8:0] strobes();
    return {refresh_stb, kb_stop_stb, kb_start_stb, flush_stb, read_stb,
            hide_stb, inval_stb, cksum_stb, prog_stb};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d, input logic wp, input logic bz, input logic [3:0] s);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wprot_en = wp; busy_in = bz; pkt_sel = s;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; wprot_en = 1'b0; busy_in = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] data;
    logic        wp;
    logic        bz;
    logic [3:0]  sel;
    logic [8:0]  exp_stb;
    logic        exp_ke;
    logic        exp_be;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{{KEY, 16'h0001}, 1'b0, 1'b0, 4'd0, 9'h001, 1'b0, 1'b0}, // R3 prog
    '{{KEY, 16'h0001}, 1'b0, 1'b0, 4'd2, 9'h000, 1'b0, 1'b0}, // R5 locked from init
    '{{KEY, 16'h0003}, 1'b0, 1'b0, 4'd2, 9'h002, 1'b0, 1'b0}, // R8 prog refused, cksum wins
    '{{KEY, 16'h0002}, 1'b0, 1'b0, 4'd1, 9'h002, 1'b0, 1'b0}, // R5 lock pkt1
    '{{KEY, 16'h0001}, 1'b0, 1'b0, 4'd1, 9'h000, 1'b0, 1'b0}, // R5 prog pkt1 refused
    '{32'h0000_0040,   1'b0, 1'b0, 4'd1, 9'h010, 1'b0, 1'b0}, // R7 read no key
    '{{KEY, 16'h0010}, 1'b0, 1'b0, 4'd1, 9'h008, 1'b0, 1'b0}, // R4 hide pkt1
    '{32'h0000_0040,   1'b0, 1'b0, 4'd1, 9'h000, 1'b0, 1'b0}, // R4 read hidden refused
    '{32'h0000_00C0,   1'b0, 1'b0, 4'd3, 9'h010, 1'b0, 1'b0}, // R8 read before flush
    '{32'h0000_8080,   1'b0, 1'b0, 4'd3, 9'h020, 1'b0, 1'b0}, // R8 flush before refresh
    '{32'h0000_8000,   1'b0, 1'b0, 4'd4, 9'h100, 1'b0, 1'b0}, // R3 refresh
    '{32'h0000_0100,   1'b0, 1'b0, 4'd4, 9'h040, 1'b0, 1'b0}, // R3 kb start
    '{32'h0000_0200,   1'b0, 1'b0, 4'd4, 9'h080, 1'b0, 1'b0}, // R3 kb stop
    '{{KEY, 16'h0004}, 1'b0, 1'b0, 4'd5, 9'h004, 1'b0, 1'b0}, // R6 invalidate pkt5
    '{{KEY, 16'h0001}, 1'b1, 1'b0, 4'd0, 9'h000, 1'b0, 1'b0}, // R1 protected
    '{32'h1234_0001,   1'b1, 1'b0, 4'd0, 9'h000, 1'b0, 1'b0}, // R1 protected, no key error
    '{32'h1234_0001,   1'b0, 1'b0, 4'd0, 9'h000, 1'b1, 1'b0}, // R2 wrong key
    '{32'h1234_0041,   1'b0, 1'b0, 4'd0, 9'h010, 1'b1, 1'b0}, // R2 R7 read still goes
    '{{KEY, 16'h0001}, 1'b0, 1'b1, 4'd0, 9'h000, 1'b1, 1'b1}, // R9 busy refuses prog
    '{32'h0000_0240,   1'b0, 1'b1, 4'd0, 9'h080, 1'b1, 1'b1}, // R9 kb stop while busy
    '{32'h0000_0080,   1'b0, 1'b1, 4'd0, 9'h020, 1'b1, 1'b1}, // R9 flush while busy
    '{{KEY, 16'h0000}, 1'b0, 1'b0, 4'd0, 9'h000, 1'b1, 1'b1}  // R3 no bits, no effect
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; wprot_en = 1'b0; busy_in = 1'b0;
    pkt_sel = '0; init_locked = 16'h0004; init_invalid = 16'h0008;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    check("R10 strobes",  {23'b0, strobes()}, 32'h0);
    check("R10 errors",   {30'b0, key_err, busy_err}, 32'h0);
    check("R10 hidden",   {16'b0, hidden_flags}, 32'h0);
    check("R10 locked",   {16'b0, locked_flags}, 32'h0004);
    check("R10 invalid",  {16'b0, invalid_flags}, 32'h0008);

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i].data, VEC[i].wp, VEC[i].bz, VEC[i].sel);
      check($sformatf("vec%0d strobes", i), {23'b0, strobes()}, {23'b0, VEC[i].exp_stb});
      check($sformatf("vec%0d key_err R2", i), {31'b0, key_err}, {31'b0, VEC[i].exp_ke});
      check($sformatf("vec%0d busy_err R9", i), {31'b0, busy_err}, {31'b0, VEC[i].exp_be});
      if (VEC[i].exp_stb != 0)
        check($sformatf("vec%0d R11 stb_pkt", i), {28'b0, stb_pkt}, {28'b0, VEC[i].sel});
    end

    // Flag tables after the vector walk
    check("R4 hidden flags",  {16'b0, hidden_flags},  32'h0002);
    check("R5 locked flags",  {16'b0, locked_flags},  32'h0006);
    check("R6 invalid flags", {16'b0, invalid_flags}, 32'h0028);

    // R1 protected hide leaves flags alone
    do_write({KEY, 16'h0010}, 1'b1, 1'b0, 4'd7);
    check("R1 hidden untouched", {16'b0, hidden_flags}, 32'h0002);

    // R2 wrong-key hide changes no flag
    do_write(32'h0000_0010, 1'b0, 1'b0, 4'd7);
    check("R2 hidden untouched", {16'b0, hidden_flags}, 32'h0002);

    // R3 strobe lasts a single cycle
    do_write(32'h0000_0080, 1'b0, 1'b0, 4'd2);
    check("R3 flush high", {31'b0, flush_stb}, 32'h1);
    @(negedge clk);
    check("R3 flush one cycle", {23'b0, strobes()}, 32'h0);

    // R10 second reset picks up new initial state
    init_locked = 16'h0001; init_invalid = 16'h0000;
    do_reset();
    check("R10 errors cleared", {30'b0, key_err, busy_err}, 32'h0);
    check("R10 hidden cleared", {16'b0, hidden_flags}, 32'h0);
    check("R10 locked reload",  {16'b0, locked_flags}, 32'h0001);
    check("R10 invalid reload", {16'b0, invalid_flags}, 32'h0);

    // R4 packet 1 readable again after reset
    do_write(32'h0000_0040, 1'b0, 1'b0, 4'd1);
    check("R4 read after reset", {23'b0, strobes()}, 32'h010);

    // R5 locked from new init refuses program
    do_write({KEY, 16'h0001}, 1'b0, 1'b0, 4'd0);
    check("R5 prog refused", {23'b0, strobes()}, 32'h0);
    do_write({KEY, 16'h0001}, 1'b0, 1'b0, 4'd2);
    check("R5 prog pkt2 unlocked", {23'b0, strobes()}, 32'h001);
    check("R11 stb_pkt pkt2", {28'b0, stb_pkt}, 32'd2);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule